// File: doc/BRIEF.md
# Indexed Load/Store Execution Unit

This unit carries out one single-register memory transfer for a 32-bit RISC core per request. The core hands over the base register value, an offset (a short immediate or a full register value), the direction of the offset, the indexing mode, the writeback request, the transfer size and the signedness of a load. The unit first evaluates the instruction's four-bit condition against the N, Z, C and V flags. A failing condition retires the instruction with no memory traffic and no register update.

For an instruction that executes, the unit forms the effective address and issues one request on a little-endian word-wide memory port with per-byte strobes. Loads return data that is placed at the low end of the result and extended by size and signedness. Stores place the source value on the byte lanes the address selects. On completion the unit gives the load result, the new base value and a branch request. The branch request is raised when the program counter is the load destination. Program-counter operands follow fixed offsets: read as a base it counts as the instruction address plus 8, and stored as data it counts as the instruction address plus 12.

Top module: `lsu_exec_unit`

## Requirements
- R1: Condition codes 0 to 15 are EQ (Z), NE (!Z), CS (C), CC (!C), MI (N), PL (!N), VS (V), VC (!V), HI (C and !Z), LS (!C or Z), GE (N==V), LT (N!=V), GT (!Z and N==V), LE (Z or N!=V), always (14) and never (15). `flags_nzcv` carries N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. A failing instruction gives `done` with `executed` low, makes no memory request and asserts no register write.
- R2: The signed offset is the offset when `op_up` is 1 and its two's-complement negation when `op_up` is 0. `off_use_reg`=1 selects `off_reg`, and 0 selects the zero-extended `off_imm`.
- R3: With `op_pre`=1 the access address is base plus the signed offset. The base is written back with that address only when `op_wb`=1.
- R4: With `op_pre`=0 the access address is the unmodified base. The base is always written back with base plus the signed offset.
- R5: `mem_user` is 1 exactly for accesses with `op_pre`=0 and `op_wb`=1.
- R6: The port is little-endian and lane k holds bits 8k+7:8k. Sizes are 0 byte, 1 halfword and 2 word. A byte uses the lane given by address bits 1:0. A halfword uses lanes 1:0 or 3:2 as address bit 1 selects. A word uses all four lanes. Store data is the byte or halfword repeated on every lane.
- R7: A load takes its byte or halfword from the selected lanes. With `op_signed`=1 it sign-extends from bit 7 (byte) or bit 15 (halfword), and otherwise it zero-extends.
- R8: With `base_is_pc`=1 the base value used is `inst_addr`+8, and `base_val` is ignored.
- R9: With `src_is_pc`=1 the stored value is `inst_addr`+12, and `store_val` is ignored.
- R10: A load with `dst_is_pc`=1 raises `branch_req` with the loaded value on `branch_target`, and `load_wen` stays low.
- R11: A memory fault (`mem_fault` with `mem_ready`) gives `faulted` and suppresses `load_wen`, `base_wen` and `branch_req`.
- R12: One request is accepted while `req_ready` is high. `mem_valid` and its address, data and strobes hold until `mem_ready`. `done` is a one-cycle pulse in the cycle after the memory handshake, or in the cycle after acceptance when the instruction is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction request present |
| req_ready | output | 1 | Unit idle and able to accept |
| cond_code | input | 4 | Condition field |
| flags_nzcv | input | 4 | Flags N,Z,C,V (bit 3 to bit 0) |
| op_load | input | 1 | 1 load, 0 store |
| op_size | input | 2 | 0 byte, 1 halfword, 2 word |
| op_signed | input | 1 | Sign-extend a load |
| op_up | input | 1 | Add (1) or subtract (0) the offset |
| op_pre | input | 1 | Pre-index (1) or post-index (0) |
| op_wb | input | 1 | Writeback request |
| base_is_pc | input | 1 | Base register is the program counter |
| src_is_pc | input | 1 | Store source is the program counter |
| dst_is_pc | input | 1 | Load destination is the program counter |
| inst_addr | input | 32 | Address of the current instruction |
| base_val | input | 32 | Base register value |
| off_use_reg | input | 1 | Take offset from off_reg |
| off_imm | input | OFF_W | Immediate offset |
| off_reg | input | 32 | Register offset |
| store_val | input | 32 | Store source value |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted and completed |
| mem_write | output | 1 | Request is a write |
| mem_user | output | 1 | Request carries user privilege |
| mem_addr | output | 32 | Byte address |
| mem_strb | output | 4 | Byte lane strobes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_fault | input | 1 | Access fault, valid with mem_ready |
| done | output | 1 | Instruction retired this cycle |
| executed | output | 1 | Retired instruction passed its condition |
| faulted | output | 1 | Retired instruction took a memory fault |
| load_wen | output | 1 | Write load_data to the destination |
| load_data | output | 32 | Extended load result |
| base_wen | output | 1 | Write base_wdata to the base register |
| base_wdata | output | 32 | New base value |
| branch_req | output | 1 | Load into the program counter |
| branch_target | output | 32 | Branch destination |

## Verification
The assertions assume that halfword addresses are even and word addresses are multiples of four, since the unit has no alignment fault. They also assume that the memory side raises `mem_ready` only while `mem_valid` is high. The stimulus uses only aligned addresses for multi-byte sizes. Its memory responder asserts ready for a single cycle, and only after it has seen a pending request, with or without added stall cycles. The request fields are driven only in the accepting cycle, so an operand captured one cycle late would show up as a wrong address or data.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN   = 32;
    localparam int BYTES  = XLEN / 8;
    localparam int LANE_W = $clog2(BYTES);

    localparam logic [XLEN-1:0] PC_BASE_ADJ  = XLEN'(8);
    localparam logic [XLEN-1:0] PC_STORE_ADJ = XLEN'(12);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FINISH = 2'd2
    } lsu_state_e;

    typedef struct packed {
        logic            load;
        xfer_size_e      size;
        logic            sgn;
        logic            up;
        logic            pre;
        logic            wb;
        logic            base_pc;
        logic            src_pc;
        logic            dst_pc;
        logic [XLEN-1:0] iaddr;
        logic [XLEN-1:0] base;
        logic [XLEN-1:0] offset;
        logic [XLEN-1:0] sdata;
    } lsu_op_t;

    // Number of bytes moved by a transfer size (reserved size acts as word).
    function automatic int unsigned size_bytes(xfer_size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return BYTES;
        endcase
    endfunction

    // Widen a right-justified load value by size and signedness.
    function automatic logic [XLEN-1:0] extend_load(logic [XLEN-1:0] raw,
                                                    xfer_size_e s, logic sgn);
        case (s)
            SZ_BYTE: return {{(XLEN-8){sgn & raw[7]}}, raw[7:0]};
            SZ_HALF: return {{(XLEN-16){sgn & raw[15]}}, raw[15:0]};
            default: return raw;
        endcase
    endfunction

endpackage

// File: rtl/lsu_cond_eval.sv
module lsu_cond_eval
    import lsu_pkg::*;
(
    input  logic [3:0] code,
    input  logic [3:0] nzcv,
    output logic       pass
);
    logic fn, fz, fc, fv;
    assign {fn, fz, fc, fv} = nzcv;

    always_comb begin
        case (cond_e'(code))
            CC_EQ:   pass = fz;
            CC_NE:   pass = !fz;
            CC_CS:   pass = fc;
            CC_CC:   pass = !fc;
            CC_MI:   pass = fn;
            CC_PL:   pass = !fn;
            CC_VS:   pass = fv;
            CC_VC:   pass = !fv;
            CC_HI:   pass = fc && !fz;
            CC_LS:   pass = !fc || fz;
            CC_GE:   pass = (fn == fv);
            CC_LT:   pass = (fn != fv);
            CC_GT:   pass = !fz && (fn == fv);
            CC_LE:   pass = fz || (fn != fv);
            CC_AL:   pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
(
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    input  logic [XLEN-1:0] iaddr,
    input  logic            base_pc,
    input  logic            up,
    input  logic            pre,
    input  logic            wb,
    output logic [XLEN-1:0] access_addr,
    output logic [XLEN-1:0] base_next,
    output logic            base_upd,
    output logic            user_acc
);
    logic [XLEN-1:0] base_eff;
    logic [XLEN-1:0] soff;

    // A program-counter base reads two instructions ahead.
    assign base_eff    = base_pc ? (iaddr + PC_BASE_ADJ) : base;
    assign soff        = up ? offset : (~offset + XLEN'(1));
    assign base_next   = base_eff + soff;
    assign access_addr = pre ? base_next : base_eff;
    // Post-indexed forms always update; pre-indexed only on request.
    assign base_upd    = !pre || wb;
    // Post-indexed with the writeback bit is the user-privilege form.
    assign user_acc    = !pre && wb;
endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
    import lsu_pkg::*;
(
    input  xfer_size_e        size,
    input  logic              sgn,
    input  logic [LANE_W-1:0] addr_lo,
    input  logic [XLEN-1:0]   store_src,
    input  logic [XLEN-1:0]   rdata,
    output logic [BYTES-1:0]  strb,
    output logic [XLEN-1:0]   wdata,
    output logic [XLEN-1:0]   load_val
);
    logic [LANE_W-1:0] lane_sel;
    logic [XLEN-1:0]   shifted;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        localparam logic [LANE_W-1:0] LN = LANE_W'(g);
        assign strb[g] = (size == SZ_BYTE) ? (addr_lo == LN) :
                         (size == SZ_HALF) ? (addr_lo[LANE_W-1:1] == LN[LANE_W-1:1]) :
                                             1'b1;
        assign wdata[8*g +: 8] = (size == SZ_BYTE) ? store_src[7:0] :
                                 (size == SZ_HALF) ? store_src[8*(g%2) +: 8] :
                                                     store_src[8*g +: 8];
    end

    always_comb begin
        case (size)
            SZ_BYTE: lane_sel = addr_lo;
            SZ_HALF: lane_sel = {addr_lo[LANE_W-1:1], 1'b0};
            default: lane_sel = '0;
        endcase
    end

    assign shifted  = rdata >> {lane_sel, 3'b000};
    assign load_val = extend_load(shifted, size, sgn);
endmodule

// File: rtl/lsu_exec_unit.sv
module lsu_exec_unit
    import lsu_pkg::*;
#(
    parameter int OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [3:0]       cond_code,
    input  logic [3:0]       flags_nzcv,
    input  logic             op_load,
    input  logic [1:0]       op_size,
    input  logic             op_signed,
    input  logic             op_up,
    input  logic             op_pre,
    input  logic             op_wb,
    input  logic             base_is_pc,
    input  logic             src_is_pc,
    input  logic             dst_is_pc,
    input  logic [XLEN-1:0]  inst_addr,
    input  logic [XLEN-1:0]  base_val,
    input  logic             off_use_reg,
    input  logic [OFF_W-1:0] off_imm,
    input  logic [XLEN-1:0]  off_reg,
    input  logic [XLEN-1:0]  store_val,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic             mem_write,
    output logic             mem_user,
    output logic [XLEN-1:0]  mem_addr,
    output logic [BYTES-1:0] mem_strb,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_fault,
    output logic             done,
    output logic             executed,
    output logic             faulted,
    output logic             load_wen,
    output logic [XLEN-1:0]  load_data,
    output logic             base_wen,
    output logic [XLEN-1:0]  base_wdata,
    output logic             branch_req,
    output logic [XLEN-1:0]  branch_target
);
    lsu_state_e      state;
    lsu_op_t         op_in, op_q;
    logic            skip_q, fault_q;
    logic [XLEN-1:0] rdata_q;
    logic            cond_pass;
    logic            base_upd;
    logic [XLEN-1:0] store_src;
    logic [XLEN-1:0] ext_val;
    logic            commit;

    lsu_cond_eval u_cond (
        .code (cond_code),
        .nzcv (flags_nzcv),
        .pass (cond_pass)
    );

    always_comb begin
        op_in.load    = op_load;
        op_in.size    = xfer_size_e'(op_size);
        op_in.sgn     = op_signed;
        op_in.up      = op_up;
        op_in.pre     = op_pre;
        op_in.wb      = op_wb;
        op_in.base_pc = base_is_pc;
        op_in.src_pc  = src_is_pc;
        op_in.dst_pc  = dst_is_pc;
        op_in.iaddr   = inst_addr;
        op_in.base    = base_val;
        op_in.offset  = off_use_reg ? off_reg : {{(XLEN-OFF_W){1'b0}}, off_imm};
        op_in.sdata   = store_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            op_q    <= '0;
            skip_q  <= 1'b0;
            fault_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q    <= op_in;
                        skip_q  <= !cond_pass;
                        fault_q <= 1'b0;
                        state   <= cond_pass ? ST_ACCESS : ST_FINISH;
                    end
                end
                ST_ACCESS: begin
                    if (mem_ready) begin
                        rdata_q <= mem_rdata;
                        fault_q <= mem_fault;
                        state   <= ST_FINISH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    lsu_addr_gen u_addr (
        .base        (op_q.base),
        .offset      (op_q.offset),
        .iaddr       (op_q.iaddr),
        .base_pc     (op_q.base_pc),
        .up          (op_q.up),
        .pre         (op_q.pre),
        .wb          (op_q.wb),
        .access_addr (mem_addr),
        .base_next   (base_wdata),
        .base_upd    (base_upd),
        .user_acc    (mem_user)
    );

    // A program-counter store source reads three instructions ahead.
    assign store_src = op_q.src_pc ? (op_q.iaddr + PC_STORE_ADJ) : op_q.sdata;

    lsu_lane_map u_lanes (
        .size      (op_q.size),
        .sgn       (op_q.sgn),
        .addr_lo   (mem_addr[LANE_W-1:0]),
        .store_src (store_src),
        .rdata     (rdata_q),
        .strb      (mem_strb),
        .wdata     (mem_wdata),
        .load_val  (ext_val)
    );

    assign req_ready     = (state == ST_IDLE);
    assign mem_valid     = (state == ST_ACCESS);
    assign mem_write     = !op_q.load;
    assign done          = (state == ST_FINISH);
    assign executed      = done && !skip_q;
    assign faulted       = executed && fault_q;
    assign commit        = executed && !fault_q;
    assign load_wen      = commit && op_q.load && !op_q.dst_pc;
    assign load_data     = ext_val;
    assign branch_req    = commit && op_q.load && op_q.dst_pc;
    assign branch_target = ext_val;
    assign base_wen      = commit && base_upd;

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_wdata) && $stable(mem_strb)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1
    skip_no_access_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !cond_pass) |=> (done && !executed && !mem_valid));

    // R3
    pre_wb_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (base_wen && op_q.pre) |-> (base_wdata == mem_addr));

    // R6
    strb_count_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> ($countones(mem_strb) == size_bytes(op_q.size)));

    // R11
    fault_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        faulted |-> (!load_wen && !base_wen && !branch_req));

    // R10
    branch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        branch_req |-> !load_wen);
endmodule

// File: tb/lsu_exec_unit_bench.sv
module lsu_exec_unit_bench;

    typedef struct packed {
        logic [3:0]  cond;
        logic [3:0]  nzcv;
        logic        ld;
        logic [1:0]  sz;
        logic        sg;
        logic        up;
        logic        pre;
        logic        wb;
        logic        bpc;
        logic        spc;
        logic        dpc;
        logic        oreg;
        logic [31:0] base;
        logic [31:0] off;
        logic [31:0] sval;
        logic [31:0] rdata;
        logic        ex;
        logic [31:0] eaddr;
        logic [31:0] edata;
        logic [3:0]  estrb;
        logic        ebw;
        logic [31:0] ebase;
        logic        euser;
    } vec_t;

    localparam int NV = 20;
    localparam logic [31:0] IADDR = 32'h0000_1000;

    localparam vec_t VT [0:NV-1] = '{
        '{4'd14,4'h0,1'b0,2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h2000,32'h10,32'hDEADBEEF,32'h0,1'b1,32'h2010,32'hDEADBEEF,4'hF,1'b0,32'h2010,1'b0},
        '{4'd14,4'h0,1'b1,2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,32'h2000,32'h20,32'h0,32'h11223344,1'b1,32'h1FE0,32'h11223344,4'hF,1'b1,32'h1FE0,1'b0},
        '{4'd14,4'h0,1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h3001,32'h4,32'hA5,32'h0,1'b1,32'h3001,32'hA5A5A5A5,4'h2,1'b1,32'h3005,1'b0},
        '{4'd14,4'h0,1'b1,2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h3003,32'h3,32'h0,32'h80FF7F01,1'b1,32'h3003,32'hFFFFFF80,4'h8,1'b1,32'h3000,1'b1},
        '{4'd14,4'h0,1'b1,2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h3002,32'h0,32'h0,32'h80FF7F01,1'b1,32'h3002,32'h000000FF,4'h4,1'b0,32'h3002,1'b0},
        '{4'd14,4'h0,1'b1,2'd1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h4000,32'h2,32'h0,32'h80017FFF,1'b1,32'h4002,32'hFFFF8001,4'hC,1'b0,32'h4002,1'b0},
        '{4'd14,4'h0,1'b1,2'd1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h4000,32'h0,32'h0,32'h80017FFF,1'b1,32'h4000,32'h00007FFF,4'h3,1'b0,32'h4000,1'b0},
        '{4'd14,4'h0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h4000,32'h2,32'h0,32'h80017FFF,1'b1,32'h4002,32'h00008001,4'hC,1'b0,32'h4002,1'b0},
        '{4'd14,4'h0,1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h4000,32'h2,32'h1234ABCD,32'h0,1'b1,32'h4002,32'hABCDABCD,4'hC,1'b0,32'h4002,1'b0},
        '{4'd14,4'h0,1'b1,2'd2,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,32'hDEAD0000,32'h4,32'h0,32'hCAFEF00D,1'b1,32'h100C,32'hCAFEF00D,4'hF,1'b1,32'h100C,1'b0},
        '{4'd14,4'h0,1'b0,2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h5000,32'h8,32'h77777777,32'h0,1'b1,32'h5008,32'h0000100C,4'hF,1'b0,32'h5008,1'b0},
        '{4'd14,4'h0,1'b1,2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,32'h6000,32'h0,32'h0,32'h00008000,1'b1,32'h6000,32'h00008000,4'hF,1'b0,32'h6000,1'b0},
        '{4'd0 ,4'h0,1'b0,2'd2,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h7000,32'h4,32'h1,32'h0,1'b0,32'h7000,32'h1,4'hF,1'b0,32'h7004,1'b0},
        '{4'd0 ,4'h4,1'b0,2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h7000,32'h0,32'h1,32'h0,1'b1,32'h7000,32'h1,4'hF,1'b0,32'h7000,1'b0},
        '{4'd12,4'h8,1'b0,2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h7000,32'h0,32'h1,32'h0,1'b0,32'h7000,32'h1,4'hF,1'b0,32'h7000,1'b0},
        '{4'd10,4'h9,1'b0,2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h7000,32'h0,32'h2,32'h0,1'b1,32'h7000,32'h2,4'hF,1'b0,32'h7000,1'b0},
        '{4'd15,4'h0,1'b0,2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h7000,32'h0,32'h1,32'h0,1'b0,32'h7000,32'h1,4'hF,1'b0,32'h7000,1'b0},
        '{4'd9 ,4'h2,1'b0,2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h7000,32'h0,32'h1,32'h0,1'b0,32'h7000,32'h1,4'hF,1'b0,32'h7000,1'b0},
        '{4'd8 ,4'h2,1'b0,2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h7000,32'h0,32'h3,32'h0,1'b1,32'h7000,32'h3,4'hF,1'b0,32'h7000,1'b0},
        '{4'd14,4'h0,1'b0,2'd2,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,32'h8000,32'h00010000,32'h55AA55AA,32'h0,1'b1,32'h8000,32'h55AA55AA,4'hF,1'b1,32'h18000,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  cond_code = 4'd0;
    logic [3:0]  flags_nzcv = 4'd0;
    logic        op_load = 1'b0, op_signed = 1'b0, op_up = 1'b0, op_pre = 1'b0, op_wb = 1'b0;
    logic [1:0]  op_size = 2'd0;
    logic        base_is_pc = 1'b0, src_is_pc = 1'b0, dst_is_pc = 1'b0, off_use_reg = 1'b0;
    logic [31:0] inst_addr = IADDR;
    logic [31:0] base_val = '0, off_reg = '0, store_val = '0;
    logic [11:0] off_imm = '0;
    logic        mem_valid, mem_write, mem_user;
    logic        mem_ready = 1'b0, mem_fault = 1'b0;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_strb;
    logic        done, executed, faulted, load_wen, base_wen, branch_req;
    logic [31:0] load_data, base_wdata, branch_target;

    always #10 clk = ~clk;

    lsu_exec_unit u_lsu_exec_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .cond_code(cond_code), .flags_nzcv(flags_nzcv), .op_load(op_load),
        .op_size(op_size), .op_signed(op_signed), .op_up(op_up), .op_pre(op_pre),
        .op_wb(op_wb), .base_is_pc(base_is_pc), .src_is_pc(src_is_pc),
        .dst_is_pc(dst_is_pc), .inst_addr(inst_addr), .base_val(base_val),
        .off_use_reg(off_use_reg), .off_imm(off_imm), .off_reg(off_reg),
        .store_val(store_val), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_write(mem_write), .mem_user(mem_user), .mem_addr(mem_addr),
        .mem_strb(mem_strb), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_fault(mem_fault), .done(done), .executed(executed), .faulted(faulted),
        .load_wen(load_wen), .load_data(load_data), .base_wen(base_wen),
        .base_wdata(base_wdata), .branch_req(branch_req), .branch_target(branch_target)
    );

    int n_chk = 0;
    int n_err = 0;

    logic        cap_seen, stall_bad;
    logic [31:0] cap_addr, cap_wdata;
    logic [3:0]  cap_strb;
    logic        cap_user, cap_write;
    logic        r_done, r_exec, r_faulted, r_lwen, r_bwen, r_breq;
    logic [31:0] r_ldata, r_bdata, r_btgt;

    task automatic chk(input string tag, input int id, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s (case %0d): actual=%h expected=%h", tag, id, act, exp);
        end
    endtask

    function automatic logic cond_model(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy & !z;
            4'd9:  return !cy | z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z & (n == v);
            4'd13: return z | (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_op(input vec_t v, input int stall, input logic flt);
        int cnt;
        cnt = 0;
        cap_seen = 1'b0;
        stall_bad = 1'b0;
        r_done = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cond_code = v.cond;    flags_nzcv = v.nzcv;  op_load = v.ld;
        op_size = v.sz;        op_signed = v.sg;     op_up = v.up;
        op_pre = v.pre;        op_wb = v.wb;         base_is_pc = v.bpc;
        src_is_pc = v.spc;     dst_is_pc = v.dpc;    off_use_reg = v.oreg;
        base_val = v.base;     off_reg = v.off;      off_imm = v.off[11:0];
        store_val = v.sval;    req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        base_val = 32'hFFFF_FFFF; off_reg = '0; off_imm = '0; store_val = '0;
        for (int k = 0; k < 40; k++) begin
            if (mem_ready) mem_ready = 1'b0;
            if (done) begin
                r_done = 1'b1;      r_exec = executed;   r_faulted = faulted;
                r_lwen = load_wen;  r_ldata = load_data;
                r_bwen = base_wen;  r_bdata = base_wdata;
                r_breq = branch_req; r_btgt = branch_target;
                break;
            end
            if (mem_valid) begin
                if (!cap_seen) begin
                    cap_seen = 1'b1;   cap_addr = mem_addr;  cap_wdata = mem_wdata;
                    cap_strb = mem_strb; cap_user = mem_user; cap_write = mem_write;
                end else if (mem_addr !== cap_addr || mem_wdata !== cap_wdata
                             || mem_strb !== cap_strb) begin
                    stall_bad = 1'b1;
                end
                if (cnt == stall) begin
                    mem_ready = 1'b1;
                    mem_rdata = v.rdata;
                    mem_fault = flt;
                end else begin
                    cnt++;
                end
            end
            @(negedge clk);
        end
        mem_fault = 1'b0;
    endtask

    task automatic check_vec(input vec_t v, input int id);
        chk("R12 done", id, 32'(r_done), 32'h1);
        chk("R1 exec", id, 32'(r_exec), 32'(v.ex));
        chk("R1 access", id, 32'(cap_seen), 32'(v.ex));
        if (v.ex) begin
            chk("R2 R3 R4 R8 addr", id, cap_addr, v.eaddr);
            chk("R6 strb", id, 32'(cap_strb), 32'(v.estrb));
            chk("R5 user", id, 32'(cap_user), 32'(v.euser));
            chk("R12 write", id, 32'(cap_write), 32'(!v.ld));
            if (!v.ld) chk("R6 R9 wdata", id, cap_wdata, v.edata);
            if (v.ld && !v.dpc) begin
                chk("R7 load_wen", id, 32'(r_lwen), 32'h1);
                chk("R7 load_data", id, r_ldata, v.edata);
            end
            if (v.dpc) begin
                chk("R10 branch_req", id, 32'(r_breq), 32'h1);
                chk("R10 target", id, r_btgt, v.edata);
                chk("R10 no load_wen", id, 32'(r_lwen), 32'h0);
            end
            chk("R3 R4 base_wen", id, 32'(r_bwen), 32'(v.ebw));
            if (v.ebw) chk("R3 R4 base", id, r_bdata, v.ebase);
        end else begin
            chk("R1 no base_wen", id, 32'(r_bwen), 32'h0);
            chk("R1 no load_wen", id, 32'(r_lwen), 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        vec_t w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 reset req_ready", 0, 32'(req_ready), 32'h1);
        chk("R12 reset mem_valid", 0, 32'(mem_valid), 32'h0);
        chk("R12 reset done", 0, 32'(done), 32'h0);
        chk("R11 reset base_wen", 0, 32'(base_wen), 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_op(VT[i], 0, 1'b0);
            check_vec(VT[i], i);
        end

        // R12: stalled memory keeps the request stable; done lasts one cycle.
        do_op(VT[0], 3, 1'b0);
        check_vec(VT[0], 100);
        chk("R12 stall stable", 100, 32'(stall_bad), 32'h0);
        @(negedge clk);
        chk("R12 done one cycle", 100, 32'(done), 32'h0);

        // R11: faulting load with writeback updates nothing.
        do_op(VT[1], 1, 1'b1);
        chk("R11 faulted", 101, 32'(r_faulted), 32'h1);
        chk("R11 no load_wen", 101, 32'(r_lwen), 32'h0);
        chk("R11 no base_wen", 101, 32'(r_bwen), 32'h0);

        // R11: faulting load into the program counter raises no branch.
        do_op(VT[11], 0, 1'b1);
        chk("R11 no branch", 102, 32'(r_breq), 32'h0);

        // R11: faulting post-indexed store leaves the base alone.
        do_op(VT[2], 0, 1'b1);
        chk("R11 store no base_wen", 103, 32'(r_bwen), 32'h0);

        // R1: every condition code against every flag pattern.
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                w = VT[0];
                w.cond = 4'(c);
                w.nzcv = 4'(f);
                do_op(w, 0, 1'b0);
                chk("R1 cond sweep", c * 16 + f, 32'(r_exec), 32'(cond_model(4'(c), 4'(f))));
                chk("R1 sweep access", c * 16 + f, 32'(cap_seen), 32'(cond_model(4'(c), 4'(f))));
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule